// File: doc/BRIEF.md
# Power-fail write-protect sequencer

This block guards a battery-backed memory while its supply collapses and returns. It reads three comparator flags from an external supply monitor: supply above the upper deselect trip, supply above the lower deselect trip, and supply above the battery switchover level. From these flags it drives a protect signal, a battery-select signal and a gated write enable for the memory. While protect is high, the memory outputs are meant to float and every host access is ignored.

The block runs a four-state sequence. In normal operation the memory is open. In the deselect window it is protected but still on the main supply. In battery backup it is protected and fed from the cell. In recovery it is protected and waiting on power-up. Each flag passes through a two-flop synchroniser and a debounce filter. A watchdog forces protection when the upper-trip comparator chatters without settling. When power returns, protection is held for a fixed number of cycles, and that hold starts over if the supply dips again.

If a host write is in flight on the cycle that protection engages, the block records this and captures the address. The host can then repair that single location.

Top module: `pf_guard`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, protect_o=1, batt_sel_o=1, mem_we_o=0, wr_cut_o=0 and wr_cut_addr_o=0. The block starts in battery backup.
- R2: Each comparator flag passes a two-flop synchroniser. A change of the synchronised value takes effect only after DEB_LEN consecutive samples at the new value. Shorter low pulses on the upper-trip flag leave protect_o at 0.
- R3: In normal operation, loss of the filtered upper-trip or lower-trip flag raises protect_o on the next cycle, with batt_sel_o still 0.
- R4: While protected, loss of the filtered switchover flag raises batt_sel_o. Its return drops batt_sel_o while protect_o stays 1. batt_sel_o=1 always implies protect_o=1.
- R5: Once the upper-trip and lower-trip flags are back, and the switchover flag is high, protect_o stays 1 for exactly REC_CYC more cycles before it drops. It never drops directly out of battery backup.
- R6: If the upper-trip or lower-trip flag is lost during the recovery hold, the block returns to the deselect window, and the full REC_CYC hold restarts on the next return.
- R7: In normal operation, the first synchronised low on any flag arms a watchdog. Unless all flags then read high for DEB_LEN consecutive samples, protect_o rises WDOG_CYC cycles after arming, even if no filtered flag has changed.
- R8: mem_we_o follows wr_req_i only while protect_o=0. While protected, mem_we_o=0 for any wr_req_i.
- R9: On the clock edge where protect_o rises, wr_cut_o takes the value of wr_req_i. If wr_req_i was 1, wr_cut_addr_o takes wr_addr_i. Both hold their values until protect_o next rises.
- R10: Loss of the switchover flag during the recovery hold moves the block directly to battery backup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_hi_i | input | 1 | Supply above upper deselect trip (asynchronous) |
| sup_lo_i | input | 1 | Supply above lower deselect trip (asynchronous) |
| sup_sw_i | input | 1 | Supply above battery switchover level (asynchronous) |
| wr_req_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| mem_we_o | output | 1 | Gated write enable to the memory |
| protect_o | output | 1 | Deselect / write protect |
| batt_sel_o | output | 1 | Memory fed from battery |
| wr_cut_o | output | 1 | A write was in flight when protection engaged |
| wr_cut_addr_o | output | ADDR_W | Address of that interrupted write |

## Verification
The bench builds the block with DEB_LEN=4, WDOG_CYC=24 and REC_CYC=40, in place of counts sized for milliseconds. These small values let a single run cover every filter, watchdog and recovery timeout many times over. With a four-sample filter, a comparator toggling every three cycles never settles, so the watchdog path becomes reachable. A 40-cycle hold is short enough to interrupt mid-way and watch the hold restart, or to cut off by a switchover loss.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PF_NORMAL  = 2'd0,
    PF_WINDOW  = 2'd1,
    PF_BATT    = 2'd2,
    PF_RECOVER = 2'd3
  } pf_state_e;

  localparam int unsigned FLAG_HI  = 0;
  localparam int unsigned FLAG_LO  = 1;
  localparam int unsigned FLAG_SW  = 2;
  localparam int unsigned NUM_FLAG = 3;
endpackage

// File: rtl/pf_flag_filter.sv
module pf_flag_filter #(
  parameter int unsigned DEB_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int unsigned RW = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(DEB_LEN - 1);

  logic          meta_q, sync_q, filt_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (sync_q == filt_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        filt_q <= sync_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/pf_sat_cnt.sv
module pf_sat_cnt #(
  parameter int unsigned MAX = 15,
  parameter int unsigned CW  = $clog2(MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pf_guard.sv
module pf_guard
  import pf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DEB_LEN  = 8,
  parameter int unsigned WDOG_CYC = 10000,
  parameter int unsigned REC_CYC  = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_hi_i,
  input  logic              sup_lo_i,
  input  logic              sup_sw_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              mem_we_o,
  output logic              protect_o,
  output logic              batt_sel_o,
  output logic              wr_cut_o,
  output logic [ADDR_W-1:0] wr_cut_addr_o
);
  localparam int unsigned WD_W  = $clog2(WDOG_CYC + 1);
  localparam int unsigned RC_W  = $clog2(REC_CYC + 1);
  localparam int unsigned HR_W  = $clog2(DEB_LEN + 1);
  localparam logic [WD_W-1:0] WD_TOP  = WD_W'(WDOG_CYC);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(REC_CYC - 1);
  localparam logic [HR_W-1:0] HR_LAST = HR_W'(DEB_LEN - 1);

  logic [NUM_FLAG-1:0] raw, sync, filt;
  assign raw = {sup_sw_i, sup_lo_i, sup_hi_i};

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    pf_flag_filter #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .sync_o (sync[g]),
      .filt_o (filt[g])
    );
  end

  pf_state_e state_q, state_d;
  logic      normal, all_hi_s, arm_ev, dis_ev, wd_arm_q, wd_trip, rec_done;
  logic [WD_W-1:0] wd_cnt;
  logic [RC_W-1:0] rec_cnt;
  logic [HR_W-1:0] hi_run;

  assign normal   = (state_q == PF_NORMAL);
  assign all_hi_s = &sync;
  assign arm_ev   = normal && !wd_arm_q && !all_hi_s;
  assign dis_ev   = normal && wd_arm_q && all_hi_s && (hi_run == HR_LAST);
  assign wd_trip  = wd_arm_q && (wd_cnt == WD_TOP);
  assign rec_done = (rec_cnt == RC_LAST);

  // watchdog: bounds time to deselect when a comparator chatters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wd_arm_q <= 1'b0;
    else if (!normal) wd_arm_q <= 1'b0;
    else if (arm_ev)  wd_arm_q <= 1'b1;
    else if (dis_ev)  wd_arm_q <= 1'b0;
  end

  pf_sat_cnt #(.MAX(WDOG_CYC), .CW(WD_W)) u_wd_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!normal || dis_ev || (!wd_arm_q && !arm_ev)),
    .inc_i  (1'b1),
    .cnt_o  (wd_cnt)
  );

  pf_sat_cnt #(.MAX(DEB_LEN), .CW(HR_W)) u_hi_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!normal || !wd_arm_q || !all_hi_s || dis_ev),
    .inc_i  (1'b1),
    .cnt_o  (hi_run)
  );

  pf_sat_cnt #(.MAX(REC_CYC), .CW(RC_W)) u_rec_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != PF_RECOVER),
    .inc_i  (1'b1),
    .cnt_o  (rec_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PF_NORMAL:
        if (!filt[FLAG_HI] || !filt[FLAG_LO] || wd_trip) state_d = PF_WINDOW;
      PF_WINDOW:
        if (!filt[FLAG_SW])                             state_d = PF_BATT;
        else if (filt[FLAG_HI] && filt[FLAG_LO])        state_d = PF_RECOVER;
      PF_BATT:
        if (filt[FLAG_SW])                              state_d = PF_WINDOW;
      PF_RECOVER:
        if (!filt[FLAG_SW])                             state_d = PF_BATT;
        else if (!filt[FLAG_HI] || !filt[FLAG_LO])      state_d = PF_WINDOW;
        else if (rec_done)                              state_d = PF_NORMAL;
      default:                                          state_d = PF_BATT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= PF_BATT;
      wr_cut_o      <= 1'b0;
      wr_cut_addr_o <= '0;
    end else begin
      state_q <= state_d;
      if (normal && state_d != PF_NORMAL) begin
        wr_cut_o <= wr_req_i;
        if (wr_req_i) wr_cut_addr_o <= wr_addr_i;
      end
    end
  end

  assign protect_o  = !normal;
  assign batt_sel_o = (state_q == PF_BATT);
  assign mem_we_o   = wr_req_i && normal;
endmodule

// File: rtl/pf_guard_chk.sv
module pf_guard_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_req_i,
  input logic              mem_we_o,
  input logic              protect_o,
  input logic              batt_sel_o,
  input logic              wr_cut_o,
  input logic [ADDR_W-1:0] wr_cut_addr_o
);
  AST_BATT_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_sel_o |-> protect_o); // R4
  AST_BATT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(batt_sel_o) |-> protect_o); // R4
  AST_ENTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_o) |-> !batt_sel_o); // R3
  AST_CLEAN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protect_o) |-> !$past(batt_sel_o)); // R5
  AST_WE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_o |-> !mem_we_o); // R8
  AST_CUT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_o) |-> (wr_cut_o == $past(wr_req_i))); // R9
  AST_CUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(protect_o) |-> ($stable(wr_cut_o) && $stable(wr_cut_addr_o))); // R9
endmodule

bind pf_guard pf_guard_chk #(.ADDR_W(ADDR_W)) u_pf_guard_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_req_i      (wr_req_i),
  .mem_we_o      (mem_we_o),
  .protect_o     (protect_o),
  .batt_sel_o    (batt_sel_o),
  .wr_cut_o      (wr_cut_o),
  .wr_cut_addr_o (wr_cut_addr_o)
);

// File: tb/pf_guard_tb_top.sv
`timescale 1ns/1ps
module pf_guard_tb_top;
  localparam int AW   = 8;
  localparam int DEB  = 4;
  localparam int WDOG = 24;
  localparam int REC  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b1, lo = 1'b1, sw = 1'b1, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic mem_we, prot, batt, cut;
  logic [AW-1:0] cut_addr;

  always #10 clk = ~clk;

  pf_guard #(.ADDR_W(AW), .DEB_LEN(DEB), .WDOG_CYC(WDOG), .REC_CYC(REC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sup_hi_i(hi), .sup_lo_i(lo), .sup_sw_i(sw),
    .wr_req_i(wr), .wr_addr_i(addr), .mem_we_o(mem_we), .protect_o(prot),
    .batt_sel_o(batt), .wr_cut_o(cut), .wr_cut_addr_o(cut_addr)
  );

  int checks = 0, errors = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 normal, 1 window, 2 battery, 3 recovery
  logic [2:0] m_ff1, m_s, m_f;
  int m_run[3];
  int m_state, m_rec, m_wd, m_hirun;
  bit m_arm, m_cut;
  logic [AW-1:0] m_addr;

  always @(posedge clk or negedge rst_n) begin : model
    logic [2:0] s_o, f_o;
    bit all_hi, nrm, arm_ev, dis_ev, trip;
    int nxt;
    if (!rst_n) begin
      m_ff1 = '0; m_s = '0; m_f = '0;
      foreach (m_run[i]) m_run[i] = 0;
      m_state = 2; m_rec = 0; m_wd = 0; m_hirun = 0; m_arm = 0;
      m_cut = 0; m_addr = '0;
    end else begin
      s_o = m_s; f_o = m_f;
      all_hi = &s_o;
      nrm = (m_state == 0);
      for (int i = 0; i < 3; i++) begin
        if (s_o[i] != f_o[i]) begin
          if (m_run[i] == DEB - 1) begin m_f[i] = s_o[i]; m_run[i] = 0; end
          else m_run[i]++;
        end else m_run[i] = 0;
      end
      m_s = m_ff1;
      m_ff1 = {sw, lo, hi};
      arm_ev = nrm && !m_arm && !all_hi;
      dis_ev = nrm && m_arm && all_hi && (m_hirun == DEB - 1);
      trip = m_arm && (m_wd >= WDOG);
      nxt = m_state;
      case (m_state)
        0: if (!f_o[0] || !f_o[1] || trip) nxt = 1;
        1: if (!f_o[2]) nxt = 2; else if (f_o[0] && f_o[1]) nxt = 3;
        2: if (f_o[2]) nxt = 1;
        default: if (!f_o[2]) nxt = 2; else if (!f_o[0] || !f_o[1]) nxt = 1;
                 else if (m_rec == REC - 1) nxt = 0;
      endcase
      if (!nrm) begin m_arm = 0; m_wd = 0; m_hirun = 0; end
      else if (arm_ev) begin m_arm = 1; m_wd = 1; m_hirun = 0; end
      else if (dis_ev) begin m_arm = 0; m_wd = 0; m_hirun = 0; end
      else if (m_arm) begin
        if (m_wd < WDOG) m_wd++;
        if (all_hi) m_hirun++; else m_hirun = 0;
      end
      if (m_state == 3) m_rec++; else m_rec = 0;
      if (nrm && nxt != 0) begin m_cut = wr; if (wr) m_addr = addr; end
      m_state = nxt;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check("R3 R5 R6 R7 R10 protect", prot, m_state != 0);
      check("R4 R10 batt_sel", batt, m_state == 2);
      check("R8 mem_we", mem_we, wr && m_state == 0);
      check("R9 wr_cut", cut, m_cut);
      check("R9 wr_cut_addr", cut_addr, m_addr);
    end
  end

  int cyc = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !timed_out) begin
      timed_out = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    check("R1 protect in reset", prot, 1);
    check("R1 batt in reset", batt, 1);
    check("R1 cut in reset", {cut, cut_addr}, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 protect after reset", prot, 1);
    check("R1 batt after reset", batt, 1);
    wait_cyc(80);
    check("R5 power-up released", prot, 0);

    wr = 1; addr = 8'h11; wait_cyc(1);
    check("R8 write passes in normal", mem_we, 1);
    wr = 0; wait_cyc(2);

    hi = 0; wait_cyc(2); hi = 1; wait_cyc(20);
    check("R2 short spike ignored", prot, 0);

    for (int k = 0; k < 10; k++) begin
      hi = 0; wait_cyc(3); hi = 1; wait_cyc(3);
    end
    check("R7 chatter trips watchdog", prot, 1);
    wait_cyc(70);
    check("R5 normal after chatter", prot, 0);

    wr = 1; addr = 8'h5A; hi = 0; wait_cyc(12);
    check("R8 write blocked when protected", mem_we, 0);
    check("R9 interrupted write flag", cut, 1);
    check("R9 interrupted write addr", cut_addr, 8'h5A);
    wr = 0; hi = 1; wait_cyc(70);

    lo = 0; wait_cyc(10);
    check("R3 lower trip alone protects", prot, 1);
    check("R3 no battery yet", batt, 0);
    hi = 0; sw = 0; wait_cyc(10);
    check("R4 battery selected", batt, 1);
    sw = 1; wait_cyc(10);
    check("R4 battery released", batt, 0);
    check("R4 still protected", prot, 1);

    hi = 1; lo = 1; wait_cyc(20);
    hi = 0; wait_cyc(6); hi = 1; wait_cyc(30);
    check("R6 recovery hold restarted", prot, 1);
    wait_cyc(40);
    check("R6 released after full hold", prot, 0);

    hi = 0; wait_cyc(10); hi = 1; wait_cyc(15);
    sw = 0; wait_cyc(8);
    check("R10 switchover loss in recovery", batt, 1);
    sw = 1; wait_cyc(80);

    hi = 0; wait_cyc(10);
    check("R9 flag overwritten by clean fail", cut, 0);
    check("R9 address kept", cut_addr, 8'h5A);
    hi = 1; wait_cyc(70);
    check("R5 final release", prot, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule